// File: doc/BRIEF.md
# Monitor Byte Handshake Link

This block carries multi-byte messages across the monitor byte of a framed serial link that delivers one four-byte frame every 125 µs. The monitor byte sits in the third slot of each frame. The block exchanges one monitor byte per frame at most. Each byte is paced by a pair of active-low handshake bits carried in the signalling octet. The sender flags data with MX and the receiver acknowledges it with MR. Both bits rest high when idle.

A message is an address byte, then one or more command bytes, then any data bytes the command needs. The sender closes a message by leaving MX high for two frames in a row, and the receiver acknowledges that end mark. The frame slicer outside the block supplies a strobe once per frame, along with the received monitor byte and the received handshake bits. The block returns its own monitor byte and handshake bits for the next outgoing frame. A byte-wide port with valid/ready hands outgoing bytes in, and a byte strobe with an end pulse hands received bytes out. This block does not decode the meaning of a message.

Top module: `mon_chan_link`

## Requirements
- R1: After reset, `tx_sc` is 2'b11 (bit 1 = MR, bit 0 = MX, both active low), `tx_mon` is 8'hFF, and `host_rvalid`, `host_reom` and `link_err` are 0.
- R2: A received byte is accepted at the second consecutive frame in which MX is low and the monitor byte is unchanged. Acceptance pulses `host_rvalid` for one clock with the byte on `host_rdata`, and this happens only once per MX-low stretch.
- R3: Every accepted byte and every accepted end-of-message drives MR low for exactly one frame, starting at the accepting frame.
- R4: If the monitor byte differs between two consecutive MX-low frames, no byte is accepted at the second of them.
- R5: If MX is high in two consecutive frames after at least one byte was accepted, the block pulses `host_reom` for one clock. Two high frames with no message open produce neither this pulse nor an MR acknowledge.
- R6: In the idle state, a host byte offered at a frame strobe is taken (`host_wready` high with that strobe). From that frame on, the byte appears on `tx_mon` with MX low. Both hold until a frame samples MR low.
- R7: After a byte is acknowledged, MX is high for exactly one frame. If the byte was not marked last and the host offers another byte at the next strobe, that byte is sent with MX low again.
- R8: After the last byte is acknowledged, or when no continuation byte is offered, MX stays high and no byte is taken until a frame samples MR low. The next frame is then idle and takes a new byte.
- R9: If a sent byte or the end mark gets no MR low within TMO_FRAMES frame strobes, the transmitter returns to idle with MX high and sets `link_err`. `link_err` clears when the next byte is taken.
- R10: While a received message is open (first byte accepted, end not yet seen), the transmitter takes no new byte from idle. It may start at the frame after the end-of-message frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-clock strobe per frame |
| rx_sc | input | 2 | Received handshake bits {MR, MX} |
| rx_mon | input | 8 | Received monitor byte |
| tx_sc | output | 2 | Sent handshake bits {MR, MX} |
| tx_mon | output | 8 | Sent monitor byte |
| host_wdata | input | 8 | Outgoing byte from host |
| host_wlast | input | 1 | Marks the outgoing byte as the last of its message |
| host_wvalid | input | 1 | Outgoing byte valid |
| host_wready | output | 1 | Outgoing byte taken this clock |
| host_rdata | output | 8 | Last accepted received byte |
| host_rvalid | output | 1 | One-clock pulse per accepted byte |
| host_reom | output | 1 | One-clock pulse per received end-of-message |
| link_err | output | 1 | Acknowledge timeout, sticky until next byte taken |

## Verification
Every result is due on the clock edge that carries the frame strobe. The receive pulses, the MR acknowledge, and the new MX level and monitor byte all settle at that edge. The bench therefore drives each frame's inputs and the strobe on a falling edge and samples on the next falling edge. Results that span frames are counted in strobes from the event that starts them. An acknowledge arrives in the third frame after a byte is sent against an echoing peer. The one-frame MX gap, the two-frame end mark and the timeout all fall at a known strobe count, and the bench checks the frame before each boundary as well as the frame at it.

// File: rtl/mon_chan_link.sv
`timescale 1ns/1ps
module mon_chan_link #(
  parameter int TMO_FRAMES = 8,
  localparam int CW = $clog2(TMO_FRAMES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_tick,
  input  logic [1:0] rx_sc,
  input  logic [7:0] rx_mon,
  output logic [1:0] tx_sc,
  output logic [7:0] tx_mon,
  input  logic [7:0] host_wdata,
  input  logic       host_wlast,
  input  logic       host_wvalid,
  output logic       host_wready,
  output logic [7:0] host_rdata,
  output logic       host_rvalid,
  output logic       host_reom,
  output logic       link_err
);
  typedef enum logic [1:0] {T_IDLE, T_SEND, T_POST, T_ENDW} tst_e;

  wire peer_mr = rx_sc[1];
  wire peer_mx = rx_sc[0];

  logic       prev_mx, taken, in_msg, mr_q;
  logic [7:0] prev_mon;

  wire accept = !peer_mx && !prev_mx && (rx_mon == prev_mon) && !taken;
  wire eom    = peer_mx && prev_mx && in_msg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_mx <= 1'b1; prev_mon <= '0; taken <= 1'b0; in_msg <= 1'b0;
      mr_q <= 1'b1; host_rdata <= '0; host_rvalid <= 1'b0; host_reom <= 1'b0;
    end else begin
      host_rvalid <= 1'b0;
      host_reom   <= 1'b0;
      if (frame_tick) begin
        prev_mx  <= peer_mx;
        prev_mon <= rx_mon;
        mr_q     <= 1'b1;
        if (peer_mx) taken <= 1'b0;
        if (accept) begin
          taken <= 1'b1; in_msg <= 1'b1; host_rdata <= rx_mon;
          host_rvalid <= 1'b1; mr_q <= 1'b0;
        end
        if (eom) begin
          in_msg <= 1'b0; host_reom <= 1'b1; mr_q <= 1'b0;
        end
      end
    end
  end

  tst_e          st;
  logic          mx_q, last_q;
  logic [7:0]    mon_q;
  logic [CW-1:0] cnt;

  wire can_load = (st == T_IDLE && !in_msg) || (st == T_POST && !last_q);
  assign host_wready = frame_tick && can_load;
  wire load   = host_wready && host_wvalid;
  wire acked  = !peer_mr;
  wire expire = (cnt == CW'(TMO_FRAMES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= T_IDLE; mx_q <= 1'b1; mon_q <= 8'hFF; last_q <= 1'b0;
      cnt <= '0; link_err <= 1'b0;
    end else if (frame_tick) begin
      case (st)
        T_IDLE, T_POST: begin
          if (load) begin
            mon_q <= host_wdata; last_q <= host_wlast; mx_q <= 1'b0;
            cnt <= '0; link_err <= 1'b0; st <= T_SEND;
          end else if (st == T_POST) begin
            cnt <= '0; st <= T_ENDW;
          end
        end
        T_SEND: begin
          if (acked) begin
            mx_q <= 1'b1; st <= T_POST;
          end else if (expire) begin
            mx_q <= 1'b1; link_err <= 1'b1; st <= T_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (acked) st <= T_IDLE;
          else if (expire) begin
            link_err <= 1'b1; st <= T_IDLE;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign tx_sc  = {mr_q, mx_q};
  assign tx_mon = mon_q;

  AST_SEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && st == T_SEND && peer_mr && !expire |=> !tx_sc[0] && $stable(tx_mon)); // R6
  AST_MR_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_sc[1]) |-> host_rvalid || host_reom); // R3
  AST_MR_ONE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && !tx_sc[1] |=> tx_sc[1]); // R3
  AST_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rvalid && host_reom)); // R5
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && in_msg && st == T_IDLE |=> st != T_SEND); // R10
  AST_ERR_MX_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_err) |-> tx_sc[0]); // R9
endmodule

// File: tb/tb_mon_chan_link.sv
`timescale 1ns/1ps
module tb_mon_chan_link;
  logic clk = 1'b0, rst_n = 1'b0, frame_tick = 1'b0;
  logic [1:0] rx_sc = 2'b11;
  logic [7:0] rx_mon = 8'h00;
  logic [1:0] tx_sc;
  logic [7:0] tx_mon, host_wdata = 8'h00, host_rdata;
  logic host_wlast = 1'b0, host_wvalid = 1'b0, host_wready;
  logic host_rvalid, host_reom, link_err;
  logic acc = 1'b0;
  int nchk = 0, nbad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mon_chan_link dut (.clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .rx_sc(rx_sc), .rx_mon(rx_mon), .tx_sc(tx_sc), .tx_mon(tx_mon),
    .host_wdata(host_wdata), .host_wlast(host_wlast), .host_wvalid(host_wvalid),
    .host_wready(host_wready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .host_reom(host_reom), .link_err(link_err));

  // rx vectors: {mx, mon, exp_valid, exp_eom, exp_mr, exp_data}
  localparam logic [19:0] RXV [0:10] = '{
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00},
    {1'b0, 8'hA5, 1'b0, 1'b0, 1'b1, 8'h00},
    {1'b0, 8'hA5, 1'b1, 1'b0, 1'b0, 8'hA5},
    {1'b0, 8'hA5, 1'b0, 1'b0, 1'b1, 8'h00},
    {1'b1, 8'hA5, 1'b0, 1'b0, 1'b1, 8'h00},
    {1'b0, 8'h3C, 1'b0, 1'b0, 1'b1, 8'h00},
    {1'b0, 8'h3D, 1'b0, 1'b0, 1'b1, 8'h00},
    {1'b0, 8'h3D, 1'b1, 1'b0, 1'b0, 8'h3D},
    {1'b1, 8'h3D, 1'b0, 1'b0, 1'b1, 8'h00},
    {1'b1, 8'h3D, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b1, 8'h3D, 1'b0, 1'b0, 1'b1, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic mr, input logic mx, input logic [7:0] mon);
    @(negedge clk);
    rx_sc = {mr, mx}; rx_mon = mon; frame_tick = 1'b1;
    #1 acc = host_wvalid && host_wready;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic do_reset();
    host_wvalid = 1'b0; host_wlast = 1'b0; rx_sc = 2'b11; rx_mon = 8'h00;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk("R1 tx_sc", tx_sc, 2'b11);
    chk("R1 tx_mon", tx_mon, 8'hFF);
    chk("R1 rvalid", host_rvalid, 0);
    chk("R1 reom", host_reom, 0);
    chk("R1 err", link_err, 0);

    for (int i = 0; i < 11; i++) begin
      logic [19:0] v;
      string tg;
      v = RXV[i];
      tg = v[10] ? "R2" : (v[9] ? "R5" : "R4");
      frame(1'b1, v[19], v[18:11]);
      chk({tg, " rvalid"}, host_rvalid, v[10]);
      chk({tg, " reom"}, host_reom, v[9]);
      chk("R3 mr", tx_sc[1], v[8]);
      if (v[10]) chk("R2 rdata", host_rdata, v[7:0]);
    end

    // two-byte message, then R8 idle after end ack
    do_reset();
    host_wvalid = 1'b1; host_wdata = 8'h11; host_wlast = 1'b0;
    frame(1, 1, 0);
    chk("R6 take", acc, 1); chk("R6 mx", tx_sc[0], 0); chk("R6 mon", tx_mon, 8'h11);
    host_wdata = 8'h22; host_wlast = 1'b1;
    frame(1, 1, 0); chk("R6 no take", acc, 0); chk("R6 hold mx", tx_sc[0], 0);
    frame(1, 1, 0); chk("R6 hold mon", tx_mon, 8'h11);
    frame(0, 1, 0); chk("R7 gap", tx_sc[0], 1);
    frame(1, 1, 0);
    chk("R7 take", acc, 1); chk("R7 mx", tx_sc[0], 0); chk("R7 mon", tx_mon, 8'h22);
    host_wdata = 8'h33; host_wlast = 1'b1;
    frame(1, 1, 0); frame(1, 1, 0); chk("R6 hold2", tx_sc[0], 0);
    frame(0, 1, 0); chk("R8 post", tx_sc[0], 1);
    frame(1, 1, 0); chk("R8 no take", acc, 0); chk("R8 eom mx", tx_sc[0], 1);
    frame(1, 1, 0); chk("R8 eom mx2", tx_sc[0], 1);
    frame(0, 1, 0); chk("R8 no take ack", acc, 0); chk("R8 mx", tx_sc[0], 1);
    frame(1, 1, 0); chk("R8 new", acc, 1); chk("R8 new mx", tx_sc[0], 0);
    chk("R8 err", link_err, 0);

    // R9 timeout
    do_reset();
    host_wvalid = 1'b1; host_wdata = 8'h77; host_wlast = 1'b1;
    frame(1, 1, 0); chk("R9 take", acc, 1);
    host_wvalid = 1'b0;
    for (int k = 1; k < 8; k++) frame(1, 1, 0);
    chk("R9 before mx", tx_sc[0], 0); chk("R9 before err", link_err, 0);
    frame(1, 1, 0); chk("R9 abort mx", tx_sc[0], 1); chk("R9 err", link_err, 1);
    frame(1, 1, 0); chk("R9 sticky", link_err, 1);
    host_wvalid = 1'b1; host_wdata = 8'h55;
    frame(1, 1, 0); chk("R9 retake", acc, 1); chk("R9 clear", link_err, 0);

    // R10 transmit blocked while receive open
    do_reset();
    frame(1, 0, 8'hAA);
    frame(1, 0, 8'hAA); chk("R2 open", host_rvalid, 1);
    host_wvalid = 1'b1; host_wdata = 8'h66; host_wlast = 1'b1;
    frame(1, 1, 8'hAA); chk("R10 blocked", acc, 0); chk("R10 mx", tx_sc[0], 1);
    frame(1, 1, 8'hAA); chk("R5 eom", host_reom, 1); chk("R10 blocked2", acc, 0);
    frame(1, 1, 8'hAA); chk("R10 start", acc, 1); chk("R10 mx low", tx_sc[0], 0);

    // R8 missing continuation becomes end mark
    do_reset();
    host_wvalid = 1'b1; host_wdata = 8'h44; host_wlast = 1'b0;
    frame(1, 1, 0); chk("R6 take D", acc, 1);
    host_wvalid = 1'b0;
    frame(1, 1, 0); frame(1, 1, 0);
    frame(0, 1, 0); chk("R7 gap D", tx_sc[0], 1);
    frame(1, 1, 0); chk("R8 end D", tx_sc[0], 1);
    frame(1, 1, 0); chk("R8 end D2", tx_sc[0], 1);
    frame(0, 1, 0);
    host_wvalid = 1'b1; host_wdata = 8'h45; host_wlast = 1'b1;
    frame(1, 1, 0); chk("R8 restart D", acc, 1); chk("R8 mon D", tx_mon, 8'h45);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule